// File: doc/BRIEF.md
# Bus Clock Prescaler Chain

This block turns a free-running system clock into a set of clock-enable pulses for the buses that hang off it. A high-speed bus enable is generated first, at a ratio set by a 4-bit encoded field. Two peripheral bus enables are then derived from the high-speed bus enable, not from the system clock, each at a ratio set by its own 3-bit encoded field. Each peripheral bus also has a timer enable. It runs at twice the peripheral bus rate whenever that bus is divided, and at the same rate when it is not.

Every output is a one-cycle pulse in the system clock domain. Logic in the same domain qualifies its registers with the pulse, so no second clock tree is needed. A ratio change never cuts a period short: each divider samples its code only at its own pulse, so the new ratio applies from the next period onward. Both encodings are non-linear. The high-speed field jumps from divide-by-16 to divide-by-64, and a cleared top bit in any field means no division, whatever the lower bits hold.

Top module: `bclk_chain`

## Requirements
- R1: In the first cycle after reset is released, all five enables are high, and with every code field at zero they stay high on every cycle.
- R2: While hb_code[3] is 0, hb_en is high on every cycle, whatever hb_code[2:0] holds.
- R3: With hb_code[3] set, hb_code[2:0] values 0,1,2,3 give an hb_en period of 2,4,8,16 cycles, and values 4,5,6,7 give 64,128,256,512 cycles.
- R4: While bit 2 of a peripheral code is 0, that bus's enable has the same period as hb_en, whatever the two low bits hold.
- R5: With bit 2 of a peripheral code set, its low bits 0,1,2,3 give a period of 2,4,8,16 hb_en periods.
- R6: When a peripheral code has bit 2 set, the matching timer enable has half the period of that peripheral enable. Otherwise the timer period equals the peripheral period.
- R7: For any ratio above one, each enable is high for exactly one cycle per period.
- R8: A code change made partway through a period does not alter that period. The new ratio applies from the following period.
- R9: A peripheral or timer enable is high only in a cycle where hb_en is also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_code | input | 4 | High-speed bus ratio code |
| pb0_code | input | 3 | Peripheral bus 0 ratio code |
| pb1_code | input | 3 | Peripheral bus 1 ratio code |
| hb_en | output | 1 | High-speed bus enable pulse |
| pb0_en | output | 1 | Peripheral bus 0 enable pulse |
| pb1_en | output | 1 | Peripheral bus 1 enable pulse |
| tm0_en | output | 1 | Timer enable for peripheral bus 0 |
| tm1_en | output | 1 | Timer enable for peripheral bus 1 |

## Verification
The bench sweeps all sixteen high-speed codes and all eight codes of each peripheral field, and measures each steady-state period against one computed from the code. The sweep catches a decoder that fills in the missing divide-by-32 step, one that reads the lower bits when the top bit is clear, and peripheral dividers that count system cycles instead of bus pulses. The timer checks cover the undivided bus, where a design that always doubled would run the timer faster than the bus. A ratio is also switched mid-period, which catches a divider that reloads at once and emits a truncated period. A monitor flags any peripheral or timer pulse that falls outside a high-speed pulse.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

    localparam int HB_CODE_W    = 4;
    localparam int PB_CODE_W    = 3;
    localparam int HB_SHIFT_MAX = 9;
    localparam int PB_SHIFT_MAX = 4;
    localparam int HB_CNT_W     = HB_SHIFT_MAX;
    localparam int PB_CNT_W     = PB_SHIFT_MAX;
    localparam int HB_SH_W      = $clog2(HB_SHIFT_MAX + 1);
    localparam int PB_SH_W      = $clog2(PB_SHIFT_MAX + 1);

    typedef struct packed {
        logic [HB_CNT_W-1:0] cnt;
    } hb_state_t;

    typedef struct packed {
        logic [PB_CNT_W-1:0] cnt;
        logic [PB_SH_W-1:0]  sh;
    } pb_state_t;

    // log2 of the high-speed ratio; the step to 32 is skipped
    function automatic logic [HB_SH_W-1:0] hb_shift(input logic [HB_CODE_W-1:0] c);
        logic [HB_SH_W-1:0] idx;
        idx = HB_SH_W'(c[HB_CODE_W-2:0]);
        if (!c[HB_CODE_W-1])
            return '0;
        return (idx < HB_SH_W'(4)) ? idx + HB_SH_W'(1) : idx + HB_SH_W'(2);
    endfunction

    // log2 of the peripheral ratio
    function automatic logic [PB_SH_W-1:0] pb_shift(input logic [PB_CODE_W-1:0] c);
        if (!c[PB_CODE_W-1])
            return '0;
        return PB_SH_W'(c[PB_CODE_W-2:0]) + PB_SH_W'(1);
    endfunction

endpackage

// File: rtl/bclk_hb_div.sv
module bclk_hb_div
    import bclk_pkg::*;
#(
    parameter int CODE_W = HB_CODE_W,
    parameter int CNT_W  = HB_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              en
);

    hb_state_t st_d, st_q;
    logic [HB_SH_W-1:0] sh;

    always_comb begin
        st_d = st_q;
        sh   = hb_shift(code);
        en   = (st_q.cnt == '0);
        if (en)
            st_d.cnt = ~({CNT_W{1'b1}} << sh);
        else
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/bclk_pb_div.sv
module bclk_pb_div
    import bclk_pkg::*;
#(
    parameter int CODE_W = PB_CODE_W,
    parameter int CNT_W  = PB_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              en,
    output logic              tmr_en
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pb_state_t st_d, st_q;
    logic [CNT_W-1:0] half;
    logic             at_zero;

    always_comb begin
        st_d    = st_q;
        at_zero = (st_q.cnt == '0);
        half    = (st_q.sh != '0) ? (ONE << (st_q.sh - 1'b1)) : '0;
        en      = tick && at_zero;
        tmr_en  = tick && (at_zero || ((st_q.sh != '0) && (st_q.cnt == half)));
        if (tick) begin
            if (at_zero) begin
                st_d.sh  = pb_shift(code);
                st_d.cnt = ~({CNT_W{1'b1}} << st_d.sh);
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/bclk_chain.sv
module bclk_chain
    import bclk_pkg::*;
#(
    parameter int N_PB = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HB_CODE_W-1:0] hb_code,
    input  logic [PB_CODE_W-1:0] pb0_code,
    input  logic [PB_CODE_W-1:0] pb1_code,
    output logic                 hb_en,
    output logic                 pb0_en,
    output logic                 pb1_en,
    output logic                 tm0_en,
    output logic                 tm1_en
);

    logic [N_PB-1:0][PB_CODE_W-1:0] pcode;
    logic [N_PB-1:0]                pen;
    logic [N_PB-1:0]                ten;

    assign pcode = {pb1_code, pb0_code};

    bclk_hb_div u_hb (
        .clk  (clk),
        .rst_n(rst_n),
        .code (hb_code),
        .en   (hb_en)
    );

    for (genvar g = 0; g < N_PB; g++) begin : g_pb
        bclk_pb_div u_pb (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (hb_en),
            .code  (pcode[g]),
            .en    (pen[g]),
            .tmr_en(ten[g])
        );
    end

    assign pb0_en = pen[0];
    assign pb1_en = pen[1];
    assign tm0_en = ten[0];
    assign tm1_en = ten[1];

endmodule

// File: rtl/bclk_chain_chk.sv
module bclk_chain_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] hb_code,
    input logic       hb_en,
    input logic       pb0_en,
    input logic       pb1_en,
    input logic       tm0_en,
    input logic       tm1_en
);

    AST_RST_ALL_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hb_en && pb0_en && pb1_en && tm0_en && tm1_en)); // R1

    AST_HB_UNDIV: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_en && !hb_code[3]) |=> hb_en); // R2

    AST_HB_DIV2: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_en && hb_code == 4'b1000) |=> !hb_en); // R3

    AST_PB0_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        pb0_en |-> hb_en); // R9

    AST_PB1_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        pb1_en |-> hb_en); // R9

    AST_TMR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (tm0_en || tm1_en) |-> hb_en); // R9

    AST_TMR_COVERS_PB: assert property (@(posedge clk) disable iff (!rst_n)
        (pb0_en |-> tm0_en) and (pb1_en |-> tm1_en)); // R6

endmodule

bind bclk_chain bclk_chain_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hb_code(hb_code),
    .hb_en  (hb_en),
    .pb0_en (pb0_en),
    .pb1_en (pb1_en),
    .tm0_en (tm0_en),
    .tm1_en (tm1_en)
);

// File: tb/tb_bclk_chain.sv
module tb_bclk_chain;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hb_code = '0;
    logic [2:0] pb0_code = '0;
    logic [2:0] pb1_code = '0;
    logic       hb_en, pb0_en, pb1_en, tm0_en, tm1_en;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int misalign = 0;

    always #2 clk = ~clk;

    bclk_chain dut (
        .clk(clk), .rst_n(rst_n), .hb_code(hb_code),
        .pb0_code(pb0_code), .pb1_code(pb1_code),
        .hb_en(hb_en), .pb0_en(pb0_en), .pb1_en(pb1_en),
        .tm0_en(tm0_en), .tm1_en(tm1_en)
    );

    // R9 monitor, sampled away from the edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && (pb0_en || pb1_en || tm0_en || tm1_en) && !hb_en)
            misalign++;
    end

    initial begin
        wait (cyc >= 190000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic bit sig(input int w);
        case (w)
            0: return hb_en;
            1: return pb0_en;
            2: return pb1_en;
            3: return tm0_en;
            default: return tm1_en;
        endcase
    endfunction

    function automatic int hb_ratio(input int c);
        int i;
        if (c < 8) return 1;
        i = c % 8;
        return (i < 4) ? (1 << (i + 1)) : (1 << (i + 2));
    endfunction

    function automatic int pb_ratio(input int c);
        if (c < 4) return 1;
        return 1 << ((c % 4) + 1);
    endfunction

    function automatic int tm_ratio(input int c);
        int p;
        p = pb_ratio(c);
        return (p > 1) ? p / 2 : p;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // steady period: gap between the 2nd and 3rd pulse seen
    task automatic meas(input int w, output int per);
        int seen = 0;
        int c = 0;
        int last = 0;
        per = 0;
        while (seen < 3) begin
            @(negedge clk);
            c++;
            if (sig(w)) begin
                seen++;
                if (seen == 3) per = c - last;
                last = c;
            end
        end
    endtask

    // cycles until the next pulse, counting from the current negedge
    task automatic gap(input int w, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sig(w));
    endtask

    initial begin
        int p;
        int n;
        int pb_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 hb", int'(hb_en), 1);
        check("R1 pb0", int'(pb0_en), 1);
        check("R1 pb1", int'(pb1_en), 1);
        check("R1 tm", int'(tm0_en && tm1_en), 1);

        // R2 R3 R7: every high-speed code
        for (int c = 0; c < 16; c++) begin
            hb_code = 4'(c);
            meas(0, p);
            check((c < 8) ? "R2 hb period" : "R3 R7 hb period", p, hb_ratio(c));
        end

        // R4 R5 R6: every peripheral code on both buses, hb divided by 2
        hb_code = 4'b1000;
        for (int c = 0; c < 8; c++) begin
            pb0_code = 3'(c);
            pb1_code = 3'(7 - c);
            meas(1, p);
            check((c < 4) ? "R4 pb0 period" : "R5 pb0 period", p, 2 * pb_ratio(c));
            meas(2, p);
            check((7 - c < 4) ? "R4 pb1 period" : "R5 pb1 period", p, 2 * pb_ratio(7 - c));
            meas(3, p);
            check("R6 tm0 period", p, 2 * tm_ratio(c));
            meas(4, p);
            check("R6 tm1 period", p, 2 * tm_ratio(7 - c));
        end

        // combined deep division
        hb_code = 4'b1101;
        pb0_code = 3'b111;
        pb1_code = 3'b011;
        meas(1, p);
        check("R5 pb0 x hb128", p, 128 * 16);
        meas(3, p);
        check("R6 tm0 x hb128", p, 128 * 8);
        meas(4, p);
        check("R4 R6 tm1 undiv", p, 128);

        // R7: one-cycle pulse width at ratio 4
        hb_code = 4'b1001;
        meas(0, p);
        @(negedge clk);
        check("R7 hb width", int'(hb_en), 0);

        // R8: change mid-period
        hb_code = 4'b1011;
        pb0_code = 3'b000;
        meas(0, p);
        repeat (5) @(negedge clk);
        hb_code = 4'b1000;
        gap(0, n);
        check("R8 old period kept", n, 11);
        gap(0, n);
        check("R8 new period", n, 2);

        // R8 on a peripheral divider
        pb0_code = 3'b110;
        meas(1, p);
        repeat (3) @(negedge clk);
        pb0_code = 3'b100;
        gap(1, n);
        check("R8 pb0 old period", n, 16 - 3);
        gap(1, n);
        check("R8 pb0 new period", n, 4);

        // R4: low bits ignored while bit 2 clear
        pb_hi = 0;
        pb0_code = 3'b011;
        meas(1, p);
        check("R4 pb0 code 011", p, 2);

        check("R9 alignment", misalign, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule